// File: doc/BRIEF.md
# Tone Disable Hold Controller

This per-channel controller keeps a record of an echo-canceller disable tone. An upstream recognizer sends a one-cycle pulse when it has accepted a disable tone. The controller then raises the tone-detect status and keeps it raised without any further tone input. Four band-quiet flags come from a power estimator: the receive and send directions, each judged in a low band (390–700 Hz, under -30 dBm0) and a high band (700–3400 Hz, under -34 dBm0). The status clears only after all four flags have stayed true for a full silence window, counted in 8 kHz sample strobes. That window is 3200 strobes, or 400 ms, by default.

Each release pulls an active-low interrupt low. The interrupt stays low until the host clears it. A per-channel select bit chooses which tone standard the recognizer applies, and the block reports that choice back. The canceller state (adapt or bypass) is held here. In automatic mode an accepted tone forces bypass. In manual mode only host writes change the state; the host reacts to the interrupt and reads the status.

Top module: `tone_hold_ctrl`

## Requirements
- R1: After reset `td_o`=0, `irq_no`=1, `bypass_o`=0 (adapt) and `tone_std_o`=0.
- R2: A cycle with `tone_valid_i`=1 makes `td_o`=1 from the next cycle on. `td_o` then stays 1 with `tone_valid_i` low, until a release.
- R3: While `td_o`=1, the status releases when `QUIET_SAMPLES` consecutive strobes have all four quiet flags at 1. `td_o` reads 0 in the cycle after the edge that takes the last of those strobes.
- R4: A strobe with any quiet flag at 0 restarts the quiet count from zero. Cycles with `sample_stb_i`=0 neither count nor restart, whatever the flag values.
- R5: A release makes `irq_no`=0 from the next cycle on. It stays 0 until a cycle with `irq_clr_i`=1. If a release and a clear fall in the same cycle, the release wins.
- R6: `irq_clr_i` sets `irq_no` back to 1 in the next cycle. A clear while no interrupt is pending has no effect on `irq_no` or `td_o`.
- R7: A `tone_valid_i` pulse while the quiet count is running keeps `td_o`=1 and restarts the count. It wins over a quiet strobe in the same cycle. The full `QUIET_SAMPLES` strobes are needed after the pulse, and no interrupt is raised in the meantime.
- R8: `tone_std_o` equals the value of `std_sel_i` from one cycle earlier. 1 selects the G.164 tone rules and 0 selects G.165.
- R9: With `auto_mode_i`=1, a `tone_valid_i` pulse sets `bypass_o`=1 in the next cycle. This holds even when `td_o` is already set, and it wins over a host write in the same cycle.
- R10: `host_wr_i`=1 loads `host_bypass_i` into `bypass_o` in the next cycle (1 = bypass, 0 = adapt). With `auto_mode_i`=0 a tone pulse leaves `bypass_o` unchanged, and a release never changes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_stb_i | input | 1 | One pulse per 8 kHz sample |
| tone_valid_i | input | 1 | Disable tone accepted (pulse) |
| rin_quiet_i | input | NUM_BANDS | Receive side below threshold; bit 0 low band, bit 1 high band |
| sin_quiet_i | input | NUM_BANDS | Send side below threshold; bit 0 low band, bit 1 high band |
| std_sel_i | input | 1 | Tone standard select: 1 G.164, 0 G.165 |
| auto_mode_i | input | 1 | Tone forces bypass when 1 |
| host_wr_i | input | 1 | Host state write strobe |
| host_bypass_i | input | 1 | Host write data: 1 bypass, 0 adapt |
| irq_clr_i | input | 1 | Host interrupt acknowledge |
| td_o | output | 1 | Tone-detect status |
| irq_no | output | 1 | Release interrupt, active low |
| tone_std_o | output | 1 | Selected tone standard |
| bypass_o | output | 1 | Canceller state: 1 bypass, 0 adapt |

## Verification
Every output is a register that is one edge away from its cause. `td_o`, `irq_no`, `bypass_o` and `tone_std_o` are therefore due in the first cycle after the edge that takes the tone pulse, host write, clear or the last quiet strobe. The bench drives inputs 1 ns after a rising edge and samples after the next edge, so each check reads the result of exactly one edge. The silence window is checked on both sides of its boundary. The status must still be set after `QUIET_SAMPLES`-1 qualifying strobes and clear after one more. Restarts caused by a noisy strobe or a new tone are checked the same way against a count restarted in the bench.

// File: rtl/tone_hold_pkg.sv
package tone_hold_pkg;

  typedef enum logic {
    STD_G165 = 1'b0,
    STD_G164 = 1'b1
  } tone_std_e;

  typedef enum logic {
    EC_ADAPT  = 1'b0,
    EC_BYPASS = 1'b1
  } ec_state_e;

endpackage

// File: rtl/tone_hold_quiet_timer.sv
module tone_hold_quiet_timer #(
  parameter int unsigned NUM_BANDS     = 2,
  parameter int unsigned QUIET_SAMPLES = 3200
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 stb_i,
  input  logic [NUM_BANDS-1:0] rin_quiet_i,
  input  logic [NUM_BANDS-1:0] sin_quiet_i,
  input  logic                 td_i,
  input  logic                 tone_i,
  output logic                 release_o
);
  localparam int unsigned CW = (QUIET_SAMPLES > 1) ? $clog2(QUIET_SAMPLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUIET_SAMPLES - 1);

  logic [NUM_BANDS-1:0] band_ok;
  logic                 quiet_all;
  logic [CW-1:0]        cnt_q, cnt_d;

  // one qualifier per band, both directions
  for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
    assign band_ok[b] = rin_quiet_i[b] & sin_quiet_i[b];
  end
  assign quiet_all = &band_ok;

  assign release_o = td_i & ~tone_i & stb_i & quiet_all & (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (tone_i || !td_i)      cnt_d = '0;
    else if (stb_i) begin
      if (!quiet_all)         cnt_d = '0;
      else if (cnt_q == LAST) cnt_d = '0;
      else                    cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  a_r3_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);

  a_r4_noisy_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (td_i && stb_i && !quiet_all) |=> (cnt_q == '0));

  a_r4_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (td_i && !tone_i && !stb_i) |=> $stable(cnt_q));

  a_r7_tone_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tone_i |=> (cnt_q == '0));

endmodule

// File: rtl/tone_hold_status.sv
module tone_hold_status (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tone_i,
  input  logic release_i,
  input  logic irq_clr_i,
  output logic td_o,
  output logic irq_no
);
  logic td_q;
  logic irq_pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        td_q <= 1'b0;
    else if (tone_i)    td_q <= 1'b1;
    else if (release_i) td_q <= 1'b0;
  end

  // release beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        irq_pend_q <= 1'b0;
    else if (release_i) irq_pend_q <= 1'b1;
    else if (irq_clr_i) irq_pend_q <= 1'b0;
  end

  assign td_o   = td_q;
  assign irq_no = ~irq_pend_q;

  a_r2_td_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (td_q && !release_i) |=> td_q);

  a_r5_irq_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(td_q) |-> irq_pend_q);

  a_r5_irq_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_pend_q && !irq_clr_i) |=> irq_pend_q);

  a_r7_no_irq_on_tone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_pend_q && tone_i) |=> !irq_pend_q);

endmodule

// File: rtl/tone_hold_state_ctl.sv
module tone_hold_state_ctl
  import tone_hold_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tone_i,
  input  logic      auto_mode_i,
  input  logic      host_wr_i,
  input  logic      host_bypass_i,
  input  logic      std_sel_i,
  output ec_state_e state_o,
  output tone_std_e std_o
);
  ec_state_e state_q;
  tone_std_e std_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    state_q <= EC_ADAPT;
    else if (auto_mode_i && tone_i) state_q <= EC_BYPASS;
    else if (host_wr_i)             state_q <= host_bypass_i ? EC_BYPASS : EC_ADAPT;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) std_q <= STD_G165;
    else         std_q <= std_sel_i ? STD_G164 : STD_G165;
  end

  assign state_o = state_q;
  assign std_o   = std_q;

  a_r9_auto_bypass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (auto_mode_i && tone_i) |=> (state_q == EC_BYPASS));

  a_r10_manual_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!auto_mode_i && !host_wr_i) |=> $stable(state_q));

endmodule

// File: rtl/tone_hold_ctrl.sv
module tone_hold_ctrl
  import tone_hold_pkg::*;
#(
  parameter int unsigned NUM_BANDS     = 2,
  parameter int unsigned QUIET_SAMPLES = 3200
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sample_stb_i,
  input  logic                 tone_valid_i,
  input  logic [NUM_BANDS-1:0] rin_quiet_i,
  input  logic [NUM_BANDS-1:0] sin_quiet_i,
  input  logic                 std_sel_i,
  input  logic                 auto_mode_i,
  input  logic                 host_wr_i,
  input  logic                 host_bypass_i,
  input  logic                 irq_clr_i,
  output logic                 td_o,
  output logic                 irq_no,
  output logic                 tone_std_o,
  output logic                 bypass_o
);
  logic      release_w;
  logic      td_w;
  ec_state_e state_w;
  tone_std_e std_w;

  tone_hold_quiet_timer #(
    .NUM_BANDS    (NUM_BANDS),
    .QUIET_SAMPLES(QUIET_SAMPLES)
  ) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stb_i      (sample_stb_i),
    .rin_quiet_i(rin_quiet_i),
    .sin_quiet_i(sin_quiet_i),
    .td_i       (td_w),
    .tone_i     (tone_valid_i),
    .release_o  (release_w)
  );

  tone_hold_status i_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tone_i   (tone_valid_i),
    .release_i(release_w),
    .irq_clr_i(irq_clr_i),
    .td_o     (td_w),
    .irq_no   (irq_no)
  );

  tone_hold_state_ctl i_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tone_i       (tone_valid_i),
    .auto_mode_i  (auto_mode_i),
    .host_wr_i    (host_wr_i),
    .host_bypass_i(host_bypass_i),
    .std_sel_i    (std_sel_i),
    .state_o      (state_w),
    .std_o        (std_w)
  );

  assign td_o       = td_w;
  assign bypass_o   = (state_w == EC_BYPASS);
  assign tone_std_o = (std_w == STD_G164);

  a_r10_release_keeps_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (release_w && !tone_valid_i && !host_wr_i) |=> $stable(bypass_o));

endmodule

// File: tb/test_tone_hold_ctrl.sv
module test_tone_hold_ctrl;
  localparam time CLK_PERIOD = 10ns;
  localparam int  N = 3200;
  localparam int  NV = 9;
  // {std, auto, wr, hb, tone, exp_td, exp_byp, exp_std}
  localparam logic [7:0] VEC [NV] = '{
    8'b1_0_0_0_0_0_0_1,
    8'b0_0_1_1_0_0_1_0,
    8'b0_0_1_0_0_0_0_0,
    8'b0_0_0_0_1_1_0_0,
    8'b0_0_0_0_0_1_0_0,
    8'b1_0_1_1_0_1_1_1,
    8'b0_1_1_0_0_1_0_0,
    8'b0_1_0_0_1_1_1_0,
    8'b0_1_1_0_1_1_1_0
  };

  logic clk = 0, rst_n = 0;
  logic stb = 0, tone = 0, std_sel = 0, auto_m = 0, wr = 0, hb = 0, clr = 0;
  logic [1:0] rq = 0, sq = 0;
  logic td, irq_n, std_o, byp;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tone_hold_ctrl i_tone_hold_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .sample_stb_i(stb), .tone_valid_i(tone),
    .rin_quiet_i(rq), .sin_quiet_i(sq), .std_sel_i(std_sel), .auto_mode_i(auto_m),
    .host_wr_i(wr), .host_bypass_i(hb), .irq_clr_i(clr),
    .td_o(td), .irq_no(irq_n), .tone_std_o(std_o), .bypass_o(byp)
  );

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1ns;
  endtask

  task automatic idle();
    stb = 0; tone = 0; wr = 0; clr = 0;
  endtask

  task automatic quiet_run(int n);
    for (int i = 0; i < n; i++) begin
      stb = 1; rq = 2'b11; sq = 2'b11; tick();
    end
    idle();
  endtask

  task automatic pulse_tone();
    tone = 1; stb = 0; tick(); idle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3); #1ns;
    // R1 reset state
    chk("R1", "td", td, 1'b0);
    chk("R1", "irq_n", irq_n, 1'b1);
    chk("R1", "bypass", byp, 1'b0);
    chk("R1", "std", std_o, 1'b0);
    rst_n = 1; tick();

    // table walk: R2 R8 R9 R10
    for (int i = 0; i < NV; i++) begin
      {std_sel, auto_m, wr, hb, tone} = VEC[i][7:3];
      stb = 0; rq = 0; sq = 0;
      tick();
      chk("R2", $sformatf("vec%0d td", i), td, VEC[i][2]);
      chk(VEC[i][6] ? "R9" : "R10", $sformatf("vec%0d bypass", i), byp, VEC[i][1]);
      chk("R8", $sformatf("vec%0d std", i), std_o, VEC[i][0]);
    end
    idle(); auto_m = 0; std_sel = 0;

    // R3 window boundary
    quiet_run(N - 1);
    chk("R3", "td before last strobe", td, 1'b1);
    chk("R5", "irq before release", irq_n, 1'b1);
    quiet_run(1);
    chk("R3", "td after last strobe", td, 1'b0);
    chk("R5", "irq after release", irq_n, 1'b0);
    chk("R10", "bypass after release", byp, 1'b1);
    quiet_run(5);
    chk("R5", "irq held", irq_n, 1'b0);
    clr = 1; tick(); idle();
    chk("R6", "irq cleared", irq_n, 1'b1);
    clr = 1; tick(); idle();
    chk("R6", "clear idle irq", irq_n, 1'b1);
    chk("R6", "clear idle td", td, 1'b0);

    // R4: noisy strobe restarts, idle cycles ignored
    pulse_tone();
    chk("R2", "td set again", td, 1'b1);
    quiet_run(100);
    for (int i = 0; i < 5; i++) begin
      stb = 0; rq = 2'b00; sq = 2'b00; tick();
    end
    quiet_run(N - 101);
    chk("R4", "td idle cycles not counted", td, 1'b1);
    quiet_run(1);
    chk("R4", "td released across idle cycles", td, 1'b0);
    clr = 1; tick(); idle();
    pulse_tone();
    quiet_run(N - 10);
    stb = 1; rq = 2'b11; sq = 2'b11; rq[1] = 0; tick(); idle();
    quiet_run(N - 1);
    chk("R4", "td after restart short", td, 1'b1);
    quiet_run(1);
    chk("R4", "td after restart full", td, 1'b0);
    clr = 1; tick(); idle();

    // R4: low band send flag
    pulse_tone();
    quiet_run(N - 1);
    stb = 1; rq = 2'b11; sq = 2'b10; tick(); idle();
    quiet_run(1);
    chk("R4", "td after send-low noisy strobe", td, 1'b1);
    quiet_run(N - 2);
    chk("R4", "td one short", td, 1'b1);
    quiet_run(1);
    chk("R4", "td released", td, 1'b0);
    clr = 1; tick(); idle();

    // R7: tone during count, with same-cycle quiet strobe
    pulse_tone();
    quiet_run(N - 5);
    tone = 1; stb = 1; rq = 2'b11; sq = 2'b11; tick(); idle();
    chk("R7", "td kept", td, 1'b1);
    quiet_run(N - 1);
    chk("R7", "td after restarted window short", td, 1'b1);
    chk("R7", "no irq during count", irq_n, 1'b1);
    // R5 release beats clear in same cycle
    clr = 1; stb = 1; rq = 2'b11; sq = 2'b11; tick(); idle();
    chk("R7", "td released", td, 1'b0);
    chk("R5", "release wins over clear", irq_n, 1'b0);
    clr = 1; tick(); idle();
    chk("R6", "irq cleared final", irq_n, 1'b1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule